// File: doc/BRIEF.md
# Shared-Comparator Merge Tree Level

This block is one stage of a merge-sort tree. It accepts 2·NP sorted record streams on a single serial input port and produces NP merged streams on a single serial output port. Output pair p is the merge of inputs 2p and 2p+1, in ascending key order. A tree stage only ever needs to emit one record per cycle, so one key comparator serves every pair of the level. A round-robin scheduler picks, each cycle, one pair that has data on both inputs and space downstream.

The input queues for all streams sit in two inferred block memories. Even-numbered inputs go to one bank and odd-numbered inputs to the other, so both head records of a pair can be read in the same cycle. Each queue keeps its own head pointer, tail pointer and occupancy count. The merged record reaches the output two cycles after the pair is scheduled. Downstream space is tracked with per-pair credits: a credit is spent when a pair is scheduled and comes back when the consumer pulses `out_return` for that pair.

Each input batch ends with an end-of-stream marker, which sorts after every key. Once one side of a pair has reached its marker, the other side drains through the level unchanged. A single output marker follows only when both sides have ended.

Top module: `merge_level`

## Requirements
- R1: Output pair p carries exactly the records accepted on inputs 2p and 2p+1. On the input port, bit 0 of `in_stream` selects the odd member of the pair and the upper bits give the pair number.
- R2: Within one batch, the keys on each output pair never decrease.
- R3: For each pair, records emitted minus `out_return` pulses never exceeds CRED. A pair holding no credit is never scheduled.
- R4: The level makes at most one comparison and emits at most one record per cycle. A record appears on the output exactly two cycles after its pair is scheduled.
- R5: A pair is scheduled only when both of its input queues hold at least one entry.
- R6: When two head keys are equal, the record from the even input is taken first. `out_side` is 0 for a record from the even input and 1 for one from the odd input.
- R7: An `in_eos` entry ranks above every key. While one side of a pair shows its marker, the other side's records are passed on. One `out_eos` record, with key 0 and side 0, is emitted only when both heads are markers, and it consumes both markers.
- R8: Among the eligible pairs, the scheduler picks the first one after the pair it granted last. After reset the search begins at pair 0.
- R9: A pair scheduled in one cycle is not scheduled in the next cycle.
- R10: `in_full[s]` is high while queue s holds QD entries. A push into a full queue is discarded.
- R11: During and right after reset, `out_valid` is low, every `in_full` bit is low and every pair holds CRED credits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Push one entry into an input queue |
| in_stream | input | $clog2(NP)+1 | Target input stream number |
| in_key | input | KW | Record key |
| in_eos | input | 1 | Entry is an end-of-stream marker |
| in_full | output | 2*NP | Per input queue: no free slot |
| out_valid | output | 1 | Output record valid |
| out_pair | output | $clog2(NP) | Output pair the record belongs to |
| out_key | output | KW | Output key (0 for a marker) |
| out_eos | output | 1 | Output end-of-stream marker |
| out_side | output | 1 | Record came from the odd input |
| out_return | input | NP | Per pair: downstream freed one slot |

## Verification
The merge is driven with random sorted batches whose keys step by 0 to 2, so equal keys occur often and expose the tie order. Batch lengths are mixed, including empty batches that carry only a marker, which tests the pass-through when one side ends early. A directed phase fills a single queue while its partner stays empty, then pushes once more; this separates correct discarding from silent overwriting. Random per-pair backpressure via `out_return` makes credits run dry at varied times, which tells correct round-robin skipping apart from stalling or over-issuing.

// File: rtl/merge_pkg.sv
package merge_pkg;

  typedef enum logic [1:0] {
    PICK_EVEN = 2'd0,
    PICK_ODD  = 2'd1,
    PICK_END  = 2'd2
  } pick_e;

  // Markers rank above every key; equal keys favour the even input.
  function automatic pick_e merge_pick(input logic even_eos,
                                       input logic odd_eos,
                                       input logic odd_less);
    if (even_eos && odd_eos) return PICK_END;
    if (even_eos)            return PICK_ODD;
    if (odd_eos)             return PICK_EVEN;
    if (odd_less)            return PICK_ODD;
    return PICK_EVEN;
  endfunction

endpackage

// File: rtl/merge_qbank.sv
module merge_qbank #(
  parameter  int NQ = 4,
  parameter  int QD = 8,
  parameter  int DW = 9,
  localparam int QW = $clog2(NQ),
  localparam int AW = $clog2(QD)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [QW-1:0] wr_q,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [QW-1:0] rd_q,
  output logic [DW-1:0] rd_data,
  input  logic          pop_en,
  input  logic [QW-1:0] pop_q,
  output logic [NQ-1:0] nonempty,
  output logic [NQ-1:0] full
);

  localparam int MD = 2 ** (QW + AW);

  logic [DW-1:0] mem [MD];
  logic [AW-1:0] head_v [NQ];
  logic [AW-1:0] tail_v [NQ];
  logic          wr_ok;

  assign wr_ok = wr_en && !full[wr_q];

  // simple dual-port array: one write, one registered read
  always_ff @(posedge clk) begin
    if (wr_ok) mem[{wr_q, tail_v[wr_q]}] <= wr_data;
    if (rd_en) rd_data <= mem[{rd_q, head_v[rd_q]}];
  end

  for (genvar q = 0; q < NQ; q++) begin : g_q
    logic [AW-1:0] head_r, tail_r;
    logic [AW:0]   cnt_r;
    logic          push_hit, pop_hit;

    assign push_hit = wr_ok && (wr_q == QW'(q));
    assign pop_hit  = pop_en && (pop_q == QW'(q));

    always_ff @(posedge clk) begin
      if (rst) begin
        head_r <= '0;
        tail_r <= '0;
        cnt_r  <= '0;
      end else begin
        if (push_hit) tail_r <= tail_r + 1'b1;
        if (pop_hit)  head_r <= head_r + 1'b1;
        if (push_hit && !pop_hit)      cnt_r <= cnt_r + 1'b1;
        else if (pop_hit && !push_hit) cnt_r <= cnt_r - 1'b1;
      end
    end

    assign head_v[q]   = head_r;
    assign tail_v[q]   = tail_r;
    assign nonempty[q] = (cnt_r != '0);
    assign full[q]     = (cnt_r == (AW+1)'(QD));
  end

endmodule

// File: rtl/merge_credit.sv
module merge_credit #(
  parameter  int NP   = 4,
  parameter  int CRED = 4,
  localparam int PW   = $clog2(NP),
  localparam int CW   = $clog2(CRED + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take_en,
  input  logic [PW-1:0] take_p,
  input  logic [NP-1:0] give,
  output logic [NP-1:0] avail
);

  for (genvar p = 0; p < NP; p++) begin : g_p
    logic [CW-1:0] cred_r;
    logic          take_hit;

    assign take_hit = take_en && (take_p == PW'(p));

    always_ff @(posedge clk) begin
      if (rst) begin
        cred_r <= CW'(CRED);
      end else if (take_hit && !give[p]) begin
        cred_r <= cred_r - 1'b1;
      end else if (give[p] && !take_hit) begin
        cred_r <= cred_r + 1'b1;
      end
    end

    assign avail[p] = (cred_r != '0);
  end

endmodule

// File: rtl/merge_sched.sv
module merge_sched #(
  parameter  int NP = 4,
  localparam int PW = $clog2(NP)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NP-1:0] elig,
  output logic          grant_valid,
  output logic [PW-1:0] grant_p
);

  logic [PW-1:0] last_r;

  // first eligible pair after the one served last
  always_comb begin
    grant_valid = 1'b0;
    grant_p     = '0;
    for (int off = 1; off <= NP; off++) begin
      if (!grant_valid && elig[(int'(last_r) + off) % NP]) begin
        grant_valid = 1'b1;
        grant_p     = PW'((int'(last_r) + off) % NP);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)              last_r <= PW'(NP - 1);
    else if (grant_valid) last_r <= grant_p;
  end

endmodule

// File: rtl/merge_level.sv
module merge_level #(
  parameter  int NP   = 4,
  parameter  int KW   = 8,
  parameter  int QD   = 8,
  parameter  int CRED = 4,
  localparam int PW   = $clog2(NP),
  localparam int SW   = PW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [SW-1:0] in_stream,
  input  logic [KW-1:0] in_key,
  input  logic          in_eos,
  output logic [2*NP-1:0] in_full,
  output logic          out_valid,
  output logic [PW-1:0] out_pair,
  output logic [KW-1:0] out_key,
  output logic          out_eos,
  output logic          out_side,
  input  logic [NP-1:0] out_return
);

  import merge_pkg::*;

  localparam int DW = KW + 1;

  logic [NP-1:0] ne_a, ne_b, full_a, full_b, cr_avail, elig;
  logic          grant_valid;
  logic [PW-1:0] grant_p;
  logic [DW-1:0] rd_a, rd_b;
  logic          s1_valid;
  logic [PW-1:0] s1_pair;
  pick_e         pick;
  logic          pop_a, pop_b;

  // ---- input queue banks: even members in bank A, odd in bank B ----
  merge_qbank #(.NQ(NP), .QD(QD), .DW(DW)) bank_a (
    .clk(clk), .rst(rst),
    .wr_en(in_valid && !in_stream[0]), .wr_q(in_stream[SW-1:1]),
    .wr_data({in_eos, in_key}),
    .rd_en(grant_valid), .rd_q(grant_p), .rd_data(rd_a),
    .pop_en(pop_a), .pop_q(s1_pair),
    .nonempty(ne_a), .full(full_a)
  );

  merge_qbank #(.NQ(NP), .QD(QD), .DW(DW)) bank_b (
    .clk(clk), .rst(rst),
    .wr_en(in_valid && in_stream[0]), .wr_q(in_stream[SW-1:1]),
    .wr_data({in_eos, in_key}),
    .rd_en(grant_valid), .rd_q(grant_p), .rd_data(rd_b),
    .pop_en(pop_b), .pop_q(s1_pair),
    .nonempty(ne_b), .full(full_b)
  );

  for (genvar p = 0; p < NP; p++) begin : g_full
    assign in_full[2*p]   = full_a[p];
    assign in_full[2*p+1] = full_b[p];
    // a pair in flight is blocked until its pop has landed
    assign elig[p] = ne_a[p] && ne_b[p] && cr_avail[p] &&
                     !(s1_valid && (s1_pair == PW'(p)));
  end

  // ---- stage 0: schedule, spend a credit, read both heads ----
  merge_sched #(.NP(NP)) sched_i (
    .clk(clk), .rst(rst), .elig(elig),
    .grant_valid(grant_valid), .grant_p(grant_p)
  );

  merge_credit #(.NP(NP), .CRED(CRED)) credit_i (
    .clk(clk), .rst(rst),
    .take_en(grant_valid), .take_p(grant_p),
    .give(out_return), .avail(cr_avail)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_pair  <= '0;
    end else begin
      s1_valid <= grant_valid;
      s1_pair  <= grant_p;
    end
  end

  // ---- stage 1: the shared comparator ----
  assign pick  = merge_pick(rd_a[KW], rd_b[KW], rd_b[KW-1:0] < rd_a[KW-1:0]);
  assign pop_a = s1_valid && (pick != PICK_ODD);
  assign pop_b = s1_valid && (pick != PICK_EVEN);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_pair  <= '0;
      out_key   <= '0;
      out_eos   <= 1'b0;
      out_side  <= 1'b0;
    end else begin
      out_valid <= s1_valid;
      out_pair  <= s1_pair;
      out_eos   <= (pick == PICK_END);
      out_side  <= (pick == PICK_ODD);
      case (pick)
        PICK_ODD:  out_key <= rd_b[KW-1:0];
        PICK_EVEN: out_key <= rd_a[KW-1:0];
        default:   out_key <= '0;
      endcase
    end
  end

endmodule

// File: rtl/merge_level_chk.sv
module merge_level_chk #(
  parameter  int NP   = 4,
  parameter  int KW   = 8,
  parameter  int CRED = 4,
  localparam int PW   = $clog2(NP)
) (
  input logic          clk,
  input logic          rst,
  input logic          out_valid,
  input logic [PW-1:0] out_pair,
  input logic [KW-1:0] out_key,
  input logic          out_eos,
  input logic [NP-1:0] out_return,
  input logic          grant_valid,
  input logic [PW-1:0] grant_p,
  input logic [NP-1:0] ne_a,
  input logic [NP-1:0] ne_b,
  input logic [NP-1:0] cr_avail
);

  localparam int OW = $clog2(CRED + 2) + 1;

  // R5
  p_both_ready_r5: assert property (@(posedge clk) disable iff (rst)
    grant_valid |-> (ne_a[grant_p] && ne_b[grant_p]));

  // R3
  p_credit_gate_r3: assert property (@(posedge clk) disable iff (rst)
    grant_valid |-> cr_avail[grant_p]);

  // R9
  p_no_repeat_r9: assert property (@(posedge clk) disable iff (rst)
    (grant_valid && $past(grant_valid)) |-> (grant_p != $past(grant_p)));

  // R4
  p_latency_r4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ($past(grant_valid, 2) && (out_pair == $past(grant_p, 2))));

  for (genvar p = 0; p < NP; p++) begin : g_p
    logic [KW-1:0] prev_key;
    logic          have_prev;
    logic [OW-1:0] outst;
    logic          hit;

    assign hit = out_valid && (out_pair == PW'(p));

    always_ff @(posedge clk) begin
      if (rst) begin
        prev_key  <= '0;
        have_prev <= 1'b0;
        outst     <= '0;
      end else begin
        if (hit) begin
          have_prev <= !out_eos;
          prev_key  <= out_key;
        end
        if (hit && !out_return[p])      outst <= outst + 1'b1;
        else if (!hit && out_return[p]) outst <= outst - 1'b1;
      end
    end

    p_sorted_r2: assert property (@(posedge clk) disable iff (rst)
      (hit && !out_eos && have_prev) |-> (out_key >= prev_key));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
      outst <= OW'(CRED));
  end

endmodule

bind merge_level merge_level_chk #(.NP(NP), .KW(KW), .CRED(CRED)) chk_i (
  .clk(clk), .rst(rst),
  .out_valid(out_valid), .out_pair(out_pair), .out_key(out_key),
  .out_eos(out_eos), .out_return(out_return),
  .grant_valid(grant_valid), .grant_p(grant_p),
  .ne_a(ne_a), .ne_b(ne_b), .cr_avail(cr_avail)
);

// File: tb/merge_level_tb_top.sv
module merge_level_tb_top;

  localparam int NP = 4, KW = 8, QD = 8, CRED = 4;
  localparam int NS = 2 * NP, PW = $clog2(NP), SW = PW + 1;
  localparam int LIMIT = 100000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic          in_valid = 1'b0;
  logic [SW-1:0] in_stream = '0;
  logic [KW-1:0] in_key = '0;
  logic          in_eos = 1'b0;
  logic [NS-1:0] in_full;
  logic          out_valid, out_eos, out_side;
  logic [PW-1:0] out_pair;
  logic [KW-1:0] out_key;
  logic [NP-1:0] out_return = '0;

  merge_level #(.NP(NP), .KW(KW), .QD(QD), .CRED(CRED)) dut_i (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_stream(in_stream), .in_key(in_key), .in_eos(in_eos),
    .in_full(in_full),
    .out_valid(out_valid), .out_pair(out_pair), .out_key(out_key),
    .out_eos(out_eos), .out_side(out_side), .out_return(out_return)
  );

  int total = 0, bad = 0, cyc = 0;

  // reference model state
  int mq_key [NS][$];
  bit mq_eos [NS][$];
  int m_cred [NP];
  int m_last;
  bit m_s1v;
  int m_s1p;
  bit e_ov, e_eos, e_side;
  int e_pair, e_key;

  // stimulus and downstream bookkeeping
  int pend_key [NS][$];
  bit pend_eos [NS][$];
  int ds_cnt [NP];
  int got [NP][$];
  int sent [NP][$];
  int eos_seen [NP];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic make_batch(input int s, input int len);
    int k;
    k = $urandom_range(0, 20);
    for (int i = 0; i < len; i++) begin
      pend_key[s].push_back(k);
      pend_eos[s].push_back(1'b0);
      k += $urandom_range(0, 2);
    end
    pend_key[s].push_back(0);
    pend_eos[s].push_back(1'b1);
  endtask

  function automatic bit elig(input int p);
    return mq_key[2*p].size() > 0 && mq_key[2*p+1].size() > 0 &&
           m_cred[p] > 0 && !(m_s1v && m_s1p == p);
  endfunction

  // mode 0: random pushes, 1: only stream 0, 2: forced push into stream 0
  task automatic step(input int mode);
    bit pv, pe, acc;
    int ps, pk, g, st;
    logic [NP-1:0] rv;
    pv = 1'b0; pe = 1'b0; ps = 0; pk = 0; g = -1; rv = '0;

    // compare against the model
    chk(out_valid === e_ov, "R4", "out_valid", int'(out_valid), int'(e_ov));
    if (e_ov && out_valid) begin
      chk(int'(out_pair) == e_pair, "R8 R9 R5", "out_pair", int'(out_pair), e_pair);
      chk(out_eos == e_eos, "R7", "out_eos", int'(out_eos), int'(e_eos));
      chk(int'(out_key) == e_key, "R2", "out_key", int'(out_key), e_key);
      chk(out_side == e_side, "R6", "out_side", int'(out_side), int'(e_side));
    end
    for (int s = 0; s < NS; s++)
      chk(in_full[s] == (mq_key[s].size() >= QD), "R10", "in_full",
          int'(in_full[s]), int'(mq_key[s].size() >= QD));

    // downstream queue that receives the output
    if (out_valid) begin
      ds_cnt[out_pair]++;
      chk(ds_cnt[out_pair] <= CRED, "R3", "downstream fill", ds_cnt[out_pair], CRED);
      if (out_eos) eos_seen[out_pair]++;
      else got[out_pair].push_back(int'(out_key));
    end
    for (int p = 0; p < NP; p++)
      if (ds_cnt[p] > 0 && $urandom_range(0, 2) == 0) begin
        ds_cnt[p]--;
        rv[p] = 1'b1;
      end

    // choose an input push
    if (mode == 1) begin
      if (pend_key[0].size() > 0) begin
        pv = 1'b1; ps = 0;
        pk = pend_key[0].pop_front(); pe = pend_eos[0].pop_front();
      end
    end else if (mode == 2) begin
      pv = 1'b1; ps = 0; pk = 255; pe = 1'b0;
    end else if ($urandom_range(0, 3) != 0) begin
      st = $urandom_range(0, NS - 1);
      for (int off = 0; off < NS; off++) begin
        int s;
        s = (st + off) % NS;
        if (!pv && pend_key[s].size() > 0 && mq_key[s].size() < QD) begin
          pv = 1'b1; ps = s;
          pk = pend_key[s].pop_front(); pe = pend_eos[s].pop_front();
        end
      end
    end
    in_valid   = pv;
    in_stream  = SW'(ps);
    in_key     = KW'(pk);
    in_eos     = pe;
    out_return = rv;

    // model update for the coming edge
    acc = pv && mq_key[ps].size() < QD;
    for (int off = 1; off <= NP; off++)
      if (g < 0 && elig((m_last + off) % NP)) g = (m_last + off) % NP;
    e_ov = m_s1v;
    if (m_s1v) begin
      int a, b;
      bit ae, be, tb;
      a = 2 * m_s1p; b = a + 1;
      ae = mq_eos[a][0]; be = mq_eos[b][0];
      e_pair = m_s1p;
      e_eos = ae && be;
      tb = !e_eos && (ae || (!be && mq_key[b][0] < mq_key[a][0]));
      e_side = tb;
      e_key = e_eos ? 0 : (tb ? mq_key[b][0] : mq_key[a][0]);
      if (e_eos || !tb) begin void'(mq_key[a].pop_front()); void'(mq_eos[a].pop_front()); end
      if (e_eos || tb)  begin void'(mq_key[b].pop_front()); void'(mq_eos[b].pop_front()); end
    end
    m_s1v = (g >= 0);
    m_s1p = g;
    if (g >= 0) begin
      m_last = g;
      m_cred[g]--;
    end
    for (int p = 0; p < NP; p++) if (rv[p]) m_cred[p]++;
    if (acc) begin
      mq_key[ps].push_back(pk);
      mq_eos[ps].push_back(pe);
      if (!pe) sent[ps / 2].push_back(pk);
    end
  endtask

  function automatic bit idle();
    for (int s = 0; s < NS; s++)
      if (pend_key[s].size() > 0 || mq_key[s].size() > 0) return 1'b0;
    for (int p = 0; p < NP; p++) if (ds_cnt[p] > 0) return 1'b0;
    return !m_s1v && !e_ov;
  endfunction

  task automatic run_random();
    while (!idle() && cyc < LIMIT) begin
      step(0);
      @(negedge clk); cyc++;
    end
  endtask

  task automatic end_round(input int round);
    for (int p = 0; p < NP; p++) begin
      int u[$];
      bit same;
      u = sent[p];
      u.sort();
      same = (u.size() == got[p].size());
      for (int i = 0; i < u.size() && same; i++) same = (u[i] == got[p][i]);
      chk(same, "R1 R2", "merged contents match sorted union", got[p].size(), u.size());
      chk(eos_seen[p] == round, "R7", "end markers", eos_seen[p], round);
      got[p].delete();
      sent[p].delete();
    end
  endtask

  initial begin
    for (int p = 0; p < NP; p++) begin
      m_cred[p] = CRED; ds_cnt[p] = 0; eos_seen[p] = 0;
    end
    m_last = NP - 1; m_s1v = 1'b0; m_s1p = 0; e_ov = 1'b0;
    e_eos = 1'b0; e_side = 1'b0; e_pair = 0; e_key = 0;

    repeat (3) @(negedge clk);
    // R11: reset state
    chk(out_valid == 1'b0, "R11", "out_valid in reset", int'(out_valid), 0);
    chk(in_full == '0, "R11", "in_full in reset", int'(in_full), 0);
    rst = 1'b0;
    chk(out_valid == 1'b0, "R11", "out_valid after reset", int'(out_valid), 0);

    // round 1: stream 0 filled alone first, stream 3 empty batch
    for (int s = 0; s < NS; s++)
      make_batch(s, s == 0 ? QD + 3 : (s == 3 ? 0 : $urandom_range(0, 12)));
    for (int i = 0; i < QD; i++) begin
      step(1);
      @(negedge clk); cyc++;
    end
    chk(in_full[0] == 1'b1, "R10", "queue 0 full", int'(in_full[0]), 1);
    step(2);   // push into full queue, must be dropped
    @(negedge clk); cyc++;
    chk(in_full[0] == 1'b1, "R10", "queue 0 still full", int'(in_full[0]), 1);
    run_random();
    end_round(1);

    // round 2: dense ties and varied lengths
    for (int s = 0; s < NS; s++) make_batch(s, $urandom_range(0, 16));
    run_random();
    end_round(2);

    // round 3: more batches to exercise credit starvation
    for (int s = 0; s < NS; s++) make_batch(s, $urandom_range(5, 20));
    run_random();
    end_round(3);

    if (cyc >= LIMIT) begin
      total++; bad++;
      $display("FAIL watchdog R4 actual=%0d expected=%0d", cyc, LIMIT);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule